// File: doc/BRIEF.md
# Keypad Controller Command Interpreter

This block interprets the command stream of a keypad-controller peripheral. It sits behind a byte-level slave port that has already been deserialized: separate strobes mark the start of a write transaction, the start of a read transaction, each received byte and each byte the host wants to read. The first byte of a write transaction is a command code. Every later byte is a parameter, counted from zero. Read bytes are produced from the command that was latched last, indexed by the same byte counter.

The block holds the peripheral's setup registers: configuration, clock setup, active time, debounce time, keypad dimensions, and three 16-bit GPIO registers (pull, direction and level). It also holds an interrupt status register and a sticky error register. It drives an active-low interrupt request whenever any status bit is set. Every parameter is range-checked. A rejected value records a bad-parameter error and requests an interrupt.

Once a command has consumed all of its parameters, the latched code becomes a retired marker (0xFF). Any further parameter byte in the same transaction is then reported as a bad parameter and has no other effect. Key events, key-FIFO overflow and PWM completion arrive as single-cycle pulses from neighbouring blocks. The key FIFO itself lives outside this block, which only pops or flushes it.

Top module: `kpc_cmd_decoder`

## Requirements
- R1: After reset the registers hold: configuration 0x80, clock 0x08, active time 125, debounce 3, keypad size 0x33, status 0x10 (not-initialised flag, bit 4), error 0x00. The interrupt output is low.
- R2: A write-start or read-start pulse clears the byte counter. In a write, byte 0 latches the command code and byte N (N≥1) is parameter N-1. In a read, byte K returns byte K of the selected value, least significant byte first.
- R3: irq_n_o is low exactly when the status register is non-zero. Status bit 0 is a key event, bit 3 is an error, bit 4 is not-initialised, and bit 5+n is PWM channel n done. The key and PWM input pulses set their bits.
- R4: Error bit 0 is bad parameter, bit 1 is unknown command, bit 2 is key overrun and bit 6 is FIFO overflow. Raising an error ORs its bit into the error register (read with command 0x8C) and sets status bit 3. A fifo_ovf_i pulse raises FIFO overflow.
- R5: Command 0x83 restores the R1 values only when its parameter is 0xAA. Any other value raises bad parameter and changes no setup register.
- R6: Command 0x90 stores the keypad size. It raises bad parameter when the low nibble is outside 3..12 or the high nibble is outside 3..8.
- R7: Command 0x8F stores the debounce time and raises bad parameter for 0. Command 0x93 stores the clock setup and raises bad parameter when bits [1:0] are 01 or 10.
- R8: The GPIO writes are 0x84 (pull), 0x85 (direction) and 0x86 (level). Parameter 0 loads the low byte and clears the high byte. Parameter 1 ORs into the high byte and retires the command. Reads 0x87 and 0x88 return direction and level, low byte first.
- R9: Reading 0x82 returns the status. It then clears the status and releases the interrupt, unless the not-initialised bit is set.
- R10: Command 0x81 stores the configuration, clears the status and pulses fifo_flush_o. Read 0x92 returns configuration bits [3:0] with the upper nibble zero. Read 0x94 returns clock bits [7:2] with bits [1:0] forced to 10.
- R11: Read 0x80 returns 0x00 and then 0x04, and any later byte returns 0x00. A read of an unknown code, or a parameter written to an unknown code, raises unknown command, and the read returns 0x00.
- R12: Single-parameter writes (0x81, 0x83, 0x8B, 0x8F, 0x90, 0x93) retire after one byte. A parameter written while the retired marker is latched raises bad parameter and leaves all setup registers unchanged.
- R13: Read 0x89 returns fifo_data_i and pulses fifo_pop_o. Read 0x8A returns fifo_data_i without popping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | Start of a write transaction |
| rd_start_i | input | 1 | Start of a read transaction |
| wr_byte_i | input | 1 | Received byte strobe |
| wr_data_i | input | 8 | Received byte |
| rd_byte_i | input | 1 | Read byte request |
| rd_data_o | output | 8 | Read byte, valid the cycle after rd_byte_i |
| key_evt_i | input | 1 | Key event pulse from the scanner |
| fifo_ovf_i | input | 1 | Key FIFO overflow pulse |
| pwm_done_i | input | 3 | PWM channel completion pulses |
| fifo_data_i | input | 8 | Head byte of the key FIFO |
| fifo_pop_o | output | 1 | Pop the key FIFO |
| fifo_flush_o | output | 1 | Empty the key FIFO |
| irq_n_o | output | 1 | Active-low interrupt request |
| cfg_o | output | 8 | Configuration register |
| clk_cfg_o | output | 8 | Clock setup register |
| act_time_o | output | 8 | Active time register |
| debounce_o | output | 8 | Debounce time register |
| key_size_o | output | 8 | Keypad size register |
| gpio_pull_o | output | 16 | GPIO pull selection |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_lvl_o | output | 16 | GPIO level |

## Verification
The assertions run on every cycle and check the following:
- a retired-marker write leaves the setup registers untouched and pulls the interrupt low;
- the not-initialised flag survives a status read;
- a 0xAA reset command restores the defaults;
- the configuration and clock reads have their forced bit fields;
- a GPIO low-byte write clears the high byte;
- a key pulse always requests an interrupt.

The arithmetic range rules can only be shown by the bench's scenarios. The bench sweeps all 256 keypad-size values, all 256 debounce values and all four clock modes. The bench scenarios also show how a sticky error accumulates across commands, multi-byte read ordering, and the sequence in which configuration writes and status reads release the interrupt.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
    localparam int GPIO_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_ID_RD    = 8'h80;
    localparam logic [7:0] OP_CFG_WR   = 8'h81;
    localparam logic [7:0] OP_STAT_RD  = 8'h82;
    localparam logic [7:0] OP_SOFT_RST = 8'h83;
    localparam logic [7:0] OP_PULL_WR  = 8'h84;
    localparam logic [7:0] OP_DIR_WR   = 8'h85;
    localparam logic [7:0] OP_LVL_WR   = 8'h86;
    localparam logic [7:0] OP_DIR_RD   = 8'h87;
    localparam logic [7:0] OP_LVL_RD   = 8'h88;
    localparam logic [7:0] OP_KEY_POP  = 8'h89;
    localparam logic [7:0] OP_KEY_PEEK = 8'h8A;
    localparam logic [7:0] OP_ACT_WR   = 8'h8B;
    localparam logic [7:0] OP_ERR_RD   = 8'h8C;
    localparam logic [7:0] OP_ROT_RD   = 8'h8E;
    localparam logic [7:0] OP_DBNC_WR  = 8'h8F;
    localparam logic [7:0] OP_SIZE_WR  = 8'h90;
    localparam logic [7:0] OP_SIZE_RD  = 8'h91;
    localparam logic [7:0] OP_CFG_RD   = 8'h92;
    localparam logic [7:0] OP_CLK_WR   = 8'h93;
    localparam logic [7:0] OP_CLK_RD   = 8'h94;
    localparam logic [7:0] OP_RETIRED  = 8'hFF;

    localparam logic [7:0] SOFT_RST_KEY = 8'hAA;
    localparam logic [15:0] ID_VALUE    = 16'h0400;

    // status bit positions
    localparam int ST_KEY    = 0;
    localparam int ST_ERR    = 3;
    localparam int ST_NOINIT = 4;
    localparam int ST_PWM0   = 5;
    localparam int PWM_CH    = 3;

    // error bit positions
    localparam int ER_BADPAR  = 0;
    localparam int ER_UNKCMD  = 1;
    localparam int ER_KEYOVR  = 2;
    localparam int ER_FIFOOVR = 6;

    // keypad dimension limits
    localparam int KS_MIN     = 3;
    localparam int KS_ROW_MAX = 12;
    localparam int KS_COL_MAX = 8;

    localparam logic [7:0] RST_CFG  = 8'h80;
    localparam logic [7:0] RST_CLK  = 8'h08;
    localparam logic [7:0] RST_ACT  = 8'd125;
    localparam logic [7:0] RST_DBNC = 8'd3;
    localparam logic [7:0] RST_SIZE = 8'h33;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] clkc;
        logic [BYTE_W-1:0] act;
        logic [BYTE_W-1:0] dbnc;
        logic [BYTE_W-1:0] ksize;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] err;
        logic [GPIO_W-1:0] pull;
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] lvl;
    } regs_t;
endpackage

// File: rtl/kpc_frame.sv
module kpc_frame #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start_i,
    input  logic             rd_start_i,
    input  logic             wr_byte_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_byte_i,
    input  logic             retire_i,
    output logic [7:0]       cmd_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             param_stb_o,
    output logic [CNT_W-1:0] pidx_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [7:0]       cmd;
        logic [CNT_W-1:0] cnt;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr_start_i || rd_start_i) begin
            f_d.cnt = '0;
        end else begin
            if (wr_byte_i && (f_q.cnt == '0)) begin
                f_d.cmd = wr_data_i;
            end else if (retire_i) begin
                f_d.cmd = 8'hFF;
            end
            if ((wr_byte_i || rd_byte_i) && (f_q.cnt != CNT_MAX)) begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.cmd <= 8'hFF;
            f_q.cnt <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign cmd_o       = f_q.cmd;
    assign cnt_o       = f_q.cnt;
    assign param_stb_o = wr_byte_i && (f_q.cnt != '0) && !wr_start_i && !rd_start_i;
    assign pidx_o      = f_q.cnt - 1'b1;
endmodule

// File: rtl/kpc_arg_chk.sv
module kpc_arg_chk
    import kpc_pkg::*;
(
    input  logic [7:0] cmd_i,
    input  logic [7:0] val_i,
    output logic       bad_o
);
    logic [3:0] rows, cols;

    assign rows = val_i[3:0];
    assign cols = val_i[7:4];

    always_comb begin
        case (cmd_i)
            OP_SOFT_RST: bad_o = (val_i != SOFT_RST_KEY);
            OP_DBNC_WR:  bad_o = (val_i == 8'h00);
            OP_SIZE_WR:  bad_o = (int'(rows) < KS_MIN) || (int'(rows) > KS_ROW_MAX) ||
                                 (int'(cols) < KS_MIN) || (int'(cols) > KS_COL_MAX);
            OP_CLK_WR:   bad_o = val_i[1] ^ val_i[0];
            OP_RETIRED:  bad_o = 1'b1;
            default:     bad_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/kpc_rd_sel.sv
module kpc_rd_sel
    import kpc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [7:0]       cmd_i,
    input  logic [CNT_W-1:0] idx_i,
    input  regs_t            regs_i,
    input  logic [7:0]       fifo_data_i,
    output logic [7:0]       data_o,
    output logic             known_o,
    output logic             pop_o,
    output logic             stat_rd_o
);
    logic [15:0] word;
    logic        single;

    always_comb begin
        word      = '0;
        single    = 1'b0;
        known_o   = 1'b1;
        pop_o     = 1'b0;
        stat_rd_o = 1'b0;
        case (cmd_i)
            OP_ID_RD:    word = ID_VALUE;
            OP_STAT_RD:  begin word = {8'h00, regs_i.status}; stat_rd_o = 1'b1; end
            OP_DIR_RD:   word = regs_i.dir;
            OP_LVL_RD:   word = regs_i.lvl;
            OP_KEY_POP:  begin word = {8'h00, fifo_data_i}; single = 1'b1; pop_o = 1'b1; end
            OP_KEY_PEEK: begin word = {8'h00, fifo_data_i}; single = 1'b1; end
            OP_ERR_RD:   word = {8'h00, regs_i.err};
            OP_ROT_RD:   word = '0;
            OP_SIZE_RD:  word = {8'h00, regs_i.ksize};
            OP_CFG_RD:   word = {12'h000, regs_i.cfg[3:0]};
            OP_CLK_RD:   word = {8'h00, regs_i.clkc[7:2], 2'b10};
            default:     known_o = 1'b0;
        endcase

        if (single || (idx_i == '0)) begin
            data_o = word[7:0];
        end else if (idx_i == CNT_W'(1)) begin
            data_o = word[15:8];
        end else begin
            data_o = 8'h00;
        end
    end
endmodule

// File: rtl/kpc_cmd_decoder.sv
module kpc_cmd_decoder
    import kpc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic              rd_start_i,
    input  logic              wr_byte_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_byte_i,
    output logic [7:0]        rd_data_o,
    input  logic              key_evt_i,
    input  logic              fifo_ovf_i,
    input  logic [PWM_CH-1:0] pwm_done_i,
    input  logic [7:0]        fifo_data_i,
    output logic              fifo_pop_o,
    output logic              fifo_flush_o,
    output logic              irq_n_o,
    output logic [7:0]        cfg_o,
    output logic [7:0]        clk_cfg_o,
    output logic [7:0]        act_time_o,
    output logic [7:0]        debounce_o,
    output logic [7:0]        key_size_o,
    output logic [GPIO_W-1:0] gpio_pull_o,
    output logic [GPIO_W-1:0] gpio_dir_o,
    output logic [GPIO_W-1:0] gpio_lvl_o
);
    localparam logic [7:0] NOINIT_MASK = 8'(1 << ST_NOINIT);

    regs_t            r_d, r_q;
    logic [7:0]       rd_data_d, rd_data_q;
    logic [7:0]       cmd_w;
    logic [CNT_W-1:0] cnt_w, pidx_w;
    logic             param_stb_w, retire_w, flush_w, bad_w;
    logic [7:0]       rd_val_w;
    logic             rd_known_w, rd_pop_w, stat_rd_w;
    logic [7:0]       err_set;
    logic [GPIO_W-1:0] hi_byte;

    kpc_frame #(.CNT_W(CNT_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start_i  (wr_start_i),
        .rd_start_i  (rd_start_i),
        .wr_byte_i   (wr_byte_i),
        .wr_data_i   (wr_data_i),
        .rd_byte_i   (rd_byte_i),
        .retire_i    (retire_w),
        .cmd_o       (cmd_w),
        .cnt_o       (cnt_w),
        .param_stb_o (param_stb_w),
        .pidx_o      (pidx_w)
    );

    kpc_arg_chk u_arg (
        .cmd_i (cmd_w),
        .val_i (wr_data_i),
        .bad_o (bad_w)
    );

    kpc_rd_sel #(.CNT_W(CNT_W)) u_rd (
        .cmd_i       (cmd_w),
        .idx_i       (cnt_w),
        .regs_i      (r_q),
        .fifo_data_i (fifo_data_i),
        .data_o      (rd_val_w),
        .known_o     (rd_known_w),
        .pop_o       (rd_pop_w),
        .stat_rd_o   (stat_rd_w)
    );

    assign hi_byte = {wr_data_i, 8'h00};

    always_comb begin
        r_d       = r_q;
        rd_data_d = rd_data_q;
        retire_w  = 1'b0;
        flush_w   = 1'b0;
        err_set   = '0;

        if (param_stb_w) begin
            case (cmd_w)
                OP_CFG_WR: begin
                    r_d.cfg    = wr_data_i;
                    r_d.status = '0;
                    flush_w    = 1'b1;
                    retire_w   = 1'b1;
                end
                OP_SOFT_RST: begin
                    retire_w = 1'b1;
                    if (!bad_w) begin
                        r_d.cfg    = RST_CFG;
                        r_d.clkc   = RST_CLK;
                        r_d.act    = RST_ACT;
                        r_d.dbnc   = RST_DBNC;
                        r_d.ksize  = RST_SIZE;
                        r_d.status = NOINIT_MASK;
                    end
                end
                OP_PULL_WR: begin
                    if (pidx_w == '0) r_d.pull = {8'h00, wr_data_i};
                    else begin r_d.pull = r_q.pull | hi_byte; retire_w = 1'b1; end
                end
                OP_DIR_WR: begin
                    if (pidx_w == '0) r_d.dir = {8'h00, wr_data_i};
                    else begin r_d.dir = r_q.dir | hi_byte; retire_w = 1'b1; end
                end
                OP_LVL_WR: begin
                    if (pidx_w == '0) r_d.lvl = {8'h00, wr_data_i};
                    else begin r_d.lvl = r_q.lvl | hi_byte; retire_w = 1'b1; end
                end
                OP_ACT_WR:  begin r_d.act   = wr_data_i; retire_w = 1'b1; end
                OP_DBNC_WR: begin r_d.dbnc  = wr_data_i; retire_w = 1'b1; end
                OP_SIZE_WR: begin r_d.ksize = wr_data_i; retire_w = 1'b1; end
                OP_CLK_WR:  begin r_d.clkc  = wr_data_i; retire_w = 1'b1; end
                OP_RETIRED: ;
                default:    err_set[ER_UNKCMD] = 1'b1;
            endcase
            if (bad_w) err_set[ER_BADPAR] = 1'b1;
        end

        if (rd_byte_i && !wr_start_i && !rd_start_i) begin
            rd_data_d = rd_known_w ? rd_val_w : 8'h00;
            if (!rd_known_w) begin
                err_set[ER_UNKCMD] = 1'b1;
            end else if (stat_rd_w && !r_q.status[ST_NOINIT]) begin
                r_d.status = '0;
            end
        end

        // event inputs from neighbouring blocks
        if (key_evt_i) r_d.status[ST_KEY] = 1'b1;
        r_d.status[ST_PWM0 +: PWM_CH] = r_d.status[ST_PWM0 +: PWM_CH] | pwm_done_i;
        if (fifo_ovf_i) err_set[ER_FIFOOVR] = 1'b1;

        if (err_set != '0) begin
            r_d.err            = r_d.err | err_set;
            r_d.status[ST_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg    <= RST_CFG;
            r_q.clkc   <= RST_CLK;
            r_q.act    <= RST_ACT;
            r_q.dbnc   <= RST_DBNC;
            r_q.ksize  <= RST_SIZE;
            r_q.status <= NOINIT_MASK;
            r_q.err    <= '0;
            r_q.pull   <= '0;
            r_q.dir    <= '0;
            r_q.lvl    <= '0;
            rd_data_q  <= '0;
        end else begin
            r_q       <= r_d;
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data_o    = rd_data_q;
    assign fifo_pop_o   = rd_byte_i && !wr_start_i && !rd_start_i && rd_pop_w;
    assign fifo_flush_o = flush_w;
    assign irq_n_o      = (r_q.status == '0);
    assign cfg_o        = r_q.cfg;
    assign clk_cfg_o    = r_q.clkc;
    assign act_time_o   = r_q.act;
    assign debounce_o   = r_q.dbnc;
    assign key_size_o   = r_q.ksize;
    assign gpio_pull_o  = r_q.pull;
    assign gpio_dir_o   = r_q.dir;
    assign gpio_lvl_o   = r_q.lvl;
endmodule

// File: rtl/kpc_cmd_decoder_chk.sv
module kpc_cmd_decoder_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_byte_i,
    input logic             wr_start_i,
    input logic             rd_start_i,
    input logic             rd_byte_i,
    input logic [7:0]       wr_data_i,
    input logic             key_evt_i,
    input logic [7:0]       cmd,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       status,
    input logic [7:0]       rd_data_o,
    input logic             irq_n_o,
    input logic [7:0]       cfg_o,
    input logic [7:0]       key_size_o,
    input logic [15:0]      gpio_dir_o
);
    logic plain_wr;
    logic plain_rd;
    assign plain_wr = wr_byte_i && !wr_start_i && !rd_start_i && !rd_byte_i;
    assign plain_rd = rd_byte_i && !wr_start_i && !rd_start_i && !wr_byte_i;

    // R12
    retired_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cnt != '0 && cmd == 8'hFF) |=>
            ($stable(cfg_o) && $stable(key_size_o) && $stable(gpio_dir_o) && !irq_n_o));

    // R9
    noinit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_rd && cmd == 8'h82 && status[4]) |=> status[4]);

    // R5
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cmd == 8'h83 && cnt == CNT_W'(1) && wr_data_i == 8'hAA) |=>
            (cfg_o == 8'h80 && key_size_o == 8'h33 && !irq_n_o));

    // R10
    cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_rd && cmd == 8'h92) |=> (rd_data_o[7:4] == 4'h0));

    // R10
    clk_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_rd && cmd == 8'h94) |=> (rd_data_o[1:0] == 2'b10));

    // R8
    gpio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_wr && cmd == 8'h85 && cnt == CNT_W'(1)) |=> (gpio_dir_o[15:8] == 8'h00));

    // R3
    key_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt_i |=> !irq_n_o);
endmodule

bind kpc_cmd_decoder kpc_cmd_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_byte_i  (wr_byte_i),
    .wr_start_i (wr_start_i),
    .rd_start_i (rd_start_i),
    .rd_byte_i  (rd_byte_i),
    .wr_data_i  (wr_data_i),
    .key_evt_i  (key_evt_i),
    .cmd        (cmd_w),
    .cnt        (cnt_w),
    .status     (r_q.status),
    .rd_data_o  (rd_data_o),
    .irq_n_o    (irq_n_o),
    .cfg_o      (cfg_o),
    .key_size_o (key_size_o),
    .gpio_dir_o (gpio_dir_o)
);

// File: tb/tb_kpc_cmd_decoder.sv
module tb_kpc_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start_i = 1'b0, rd_start_i = 1'b0, wr_byte_i = 1'b0, rd_byte_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        key_evt_i = 1'b0, fifo_ovf_i = 1'b0;
    logic [2:0]  pwm_done_i = 3'b000;
    logic [7:0]  fifo_data_i = 8'h00;
    logic [7:0]  rd_data_o;
    logic        fifo_pop_o, fifo_flush_o, irq_n_o;
    logic [7:0]  cfg_o, clk_cfg_o, act_time_o, debounce_o, key_size_o;
    logic [15:0] gpio_pull_o, gpio_dir_o, gpio_lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    int pops = 0;
    int flushes = 0;

    always #4 clk = ~clk;

    kpc_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .wr_start_i(wr_start_i), .rd_start_i(rd_start_i),
        .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
        .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o),
        .key_evt_i(key_evt_i), .fifo_ovf_i(fifo_ovf_i), .pwm_done_i(pwm_done_i),
        .fifo_data_i(fifo_data_i), .fifo_pop_o(fifo_pop_o), .fifo_flush_o(fifo_flush_o),
        .irq_n_o(irq_n_o), .cfg_o(cfg_o), .clk_cfg_o(clk_cfg_o),
        .act_time_o(act_time_o), .debounce_o(debounce_o), .key_size_o(key_size_o),
        .gpio_pull_o(gpio_pull_o), .gpio_dir_o(gpio_dir_o), .gpio_lvl_o(gpio_lvl_o)
    );

    always @(posedge clk) begin
        if (fifo_pop_o) pops++;
        if (fifo_flush_o) flushes++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wstart();
        @(negedge clk); wr_start_i = 1'b1;
        @(negedge clk); wr_start_i = 1'b0;
    endtask

    task automatic rstart();
        @(negedge clk); rd_start_i = 1'b1;
        @(negedge clk); rd_start_i = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b);
        @(negedge clk); wr_byte_i = 1'b1; wr_data_i = b;
        @(negedge clk); wr_byte_i = 1'b0;
    endtask

    task automatic rbyte(output logic [7:0] d);
        @(negedge clk); rd_byte_i = 1'b1;
        @(negedge clk); rd_byte_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic send(input logic [7:0] cmd, input int n, input logic [7:0] p0, input logic [7:0] p1);
        wstart();
        wbyte(cmd);
        if (n > 0) wbyte(p0);
        if (n > 1) wbyte(p1);
    endtask

    task automatic read1(input logic [7:0] cmd, output logic [7:0] d);
        send(cmd, 0, 8'h00, 8'h00);
        rstart();
        rbyte(d);
    endtask

    task automatic pulse_key();
        @(negedge clk); key_evt_i = 1'b1;
        @(negedge clk); key_evt_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        logic [7:0] d, d2, d3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check("R1 cfg", cfg_o, 8'h80);
        check("R1 clk", clk_cfg_o, 8'h08);
        check("R1 act", act_time_o, 125);
        check("R1 dbnc", debounce_o, 3);
        check("R1 size", key_size_o, 8'h33);
        check("R1 irq_n", irq_n_o, 0);

        // R9 status read keeps not-initialised set
        read1(8'h82, d);
        check("R9 status", d, 8'h10);
        check("R9 irq held", irq_n_o, 0);

        // R10 configuration write clears status, flushes
        send(8'h81, 1, 8'h5B, 8'h00);
        check("R10 cfg", cfg_o, 8'h5B);
        check("R10 irq released", irq_n_o, 1);
        check("R10 flush", flushes, 1);
        read1(8'h92, d);
        check("R10 cfg read", d, 8'h0B);
        read1(8'h94, d);
        check("R10 clk read", d, 8'h0A);
        read1(8'h8C, d);
        check("R4 error clear", d, 8'h00);

        // R11 id read, two transactions to show counter clear (R2)
        send(8'h80, 0, 8'h00, 8'h00);
        rstart(); rbyte(d); rbyte(d2); rbyte(d3);
        check("R11 id lo", d, 8'h00);
        check("R11 id hi", d2, 8'h04);
        check("R11 id past", d3, 8'h00);
        rstart(); rbyte(d);
        check("R2 read restart", d, 8'h00);

        // R11 unknown command write and read
        send(8'h70, 1, 8'h12, 8'h00);
        check("R11 unk irq", irq_n_o, 0);
        read1(8'h8C, d);
        check("R11 unk err", d, 8'h02);
        read1(8'h82, d);
        check("R4 status err", d, 8'h08);
        check("R9 irq cleared", irq_n_o, 1);
        read1(8'h71, d);
        check("R11 unk read data", d, 8'h00);
        read1(8'h82, d);
        check("R11 unk read status", d, 8'h08);

        // R8 GPIO two-byte writes, R12 extra byte
        send(8'h85, 2, 8'h34, 8'h12);
        check("R8 dir", gpio_dir_o, 16'h1234);
        check("R8 irq", irq_n_o, 1);
        send(8'h84, 2, 8'hA5, 8'h5A);
        check("R8 pull", gpio_pull_o, 16'h5AA5);
        send(8'h86, 1, 8'hC3, 8'h00);
        check("R8 lvl low only", gpio_lvl_o, 16'h00C3);
        wstart(); wbyte(8'h86); wbyte(8'h01); wbyte(8'hF0);
        check("R8 lvl or", gpio_lvl_o, 16'hF001);
        send(8'h87, 0, 8'h00, 8'h00);
        rstart(); rbyte(d); rbyte(d2);
        check("R8 dir rd lo", d, 8'h34);
        check("R8 dir rd hi", d2, 8'h12);
        send(8'h88, 0, 8'h00, 8'h00);
        rstart(); rbyte(d); rbyte(d2);
        check("R8 lvl rd", {d2, d}, 16'hF001);
        // R12 a third byte after retirement
        wstart(); wbyte(8'h85); wbyte(8'h00); wbyte(8'hFF); wbyte(8'h77);
        check("R12 dir kept", gpio_dir_o, 16'hFF00);
        check("R12 irq", irq_n_o, 0);
        read1(8'h8C, d);
        check("R12 err", d, 8'h03);
        read1(8'h82, d);
        check("R12 status", d, 8'h08);

        // R12 single parameter retires
        send(8'h8B, 2, 8'h40, 8'h41);
        check("R12 act", act_time_o, 8'h40);
        read1(8'h82, d);
        check("R12 act status", d, 8'h08);

        // R5 soft reset
        send(8'h83, 1, 8'h55, 8'h00);
        check("R5 bad key cfg", cfg_o, 8'h5B);
        read1(8'h82, d);
        check("R5 bad key status", d, 8'h08);
        send(8'h83, 1, 8'hAA, 8'h00);
        check("R5 cfg", cfg_o, 8'h80);
        check("R5 act", act_time_o, 125);
        check("R5 dir kept", gpio_dir_o, 16'hFF00);
        read1(8'h82, d);
        check("R5 status", d, 8'h10);
        send(8'h81, 1, 8'h00, 8'h00);
        check("R1 irq after cfg", irq_n_o, 1);

        // R6 keypad size sweep
        for (int v = 0; v < 256; v++) begin
            int lo, hi, bad;
            lo = v & 15; hi = v >> 4;
            bad = (lo < 3 || lo > 12 || hi < 3 || hi > 8) ? 1 : 0;
            send(8'h90, 1, 8'(v), 8'h00);
            check("R6 size", key_size_o, v);
            read1(8'h82, d);
            check("R6 status", d, bad * 8);
        end
        read1(8'h91, d);
        check("R6 size read", d, 8'hFF);

        // R7 debounce sweep
        for (int v = 0; v < 256; v++) begin
            send(8'h8F, 1, 8'(v), 8'h00);
            check("R7 dbnc", debounce_o, v);
            read1(8'h82, d);
            check("R7 dbnc status", d, (v == 0) ? 8 : 0);
        end

        // R7 clock modes
        for (int m = 0; m < 4; m++) begin
            send(8'h93, 1, 8'(8'hC4 | m), 8'h00);
            check("R7 clk", clk_cfg_o, 8'hC4 | m);
            read1(8'h82, d);
            check("R7 clk status", d, (m == 1 || m == 2) ? 8 : 0);
            read1(8'h94, d);
            check("R10 clk format", d, 8'hC6);
        end

        // R3 event inputs
        pulse_key();
        check("R3 key irq", irq_n_o, 0);
        read1(8'h82, d);
        check("R3 key status", d, 8'h01);
        check("R3 irq release", irq_n_o, 1);
        @(negedge clk); pwm_done_i = 3'b010;
        @(negedge clk); pwm_done_i = 3'b000;
        read1(8'h82, d);
        check("R3 pwm status", d, 8'h40);

        // R4 fifo overflow
        @(negedge clk); fifo_ovf_i = 1'b1;
        @(negedge clk); fifo_ovf_i = 1'b0;
        read1(8'h8C, d);
        check("R4 fifo ovf err", d, 8'h43);
        read1(8'h82, d);
        check("R4 fifo ovf status", d, 8'h08);

        // R13 key FIFO access
        fifo_data_i = 8'h3C;
        read1(8'h8A, d);
        check("R13 peek", d, 8'h3C);
        check("R13 no pop", pops, 0);
        read1(8'h89, d);
        check("R13 pop data", d, 8'h3C);
        check("R13 pop", pops, 1);

        finish_run();
    end
endmodule